// File: doc/BRIEF.md
# DMA Channel Arbiter with Global Run Control

This block is the central scheduler of an eight-channel DMA engine. It holds one 32-bit global control word that software writes and reads. The word carries a run enable, a stop-status flag, a priority-mode select and a four-bit halt field. From the per-channel request lines it picks one channel at a time, using either a fixed order or a rotating order. While a channel owns the engine, the block drives the system bus request high.

Ownership changes only at a transfer gap. A gap is a point where the bus request drops for a fixed number of clocks before the next arbitration. The granted channel's transfer mode decides where gaps fall: block mode, burst mode or demand mode. The datapath reports each completed beat through a single-cycle strobe, together with end-of-block and end-of-transfer flags. Clearing the run enable, or writing a nonzero halt value, takes effect only at the next gap. The stop-status flag then tells software that the engine has gone quiet.

Top module: `dmac_gctl_core`

## Requirements
- R1: After reset the control word reads 0, the bus request is low and no channel is granted.
- R2: Bits 29 and 23:0 of the control word always read 0 and ignore writes. Bit 30 (stop status) ignores writes. Writing all ones reads back 32'h9F00_0000. The fields are: bit 31 run enable, bit 30 stop status, bit 28 rotate select, bits 27:24 halt.
- R3: While the run enable is 0 or the halt field is nonzero, no new grant is issued and the bus request stays low.
- R4: With rotate select 0, the requesting channel with the lowest index wins.
- R5: With rotate select 1, the search starts at the channel after the one granted most recently, wrapping from 7 to 0.
- R6: At most one grant bit is set. The grant and the bus request stay constant between gaps.
- R7: Channel mode is 2 bits per channel, at ch_mode_i[2c+1:2c], with 00 = block, 01 = burst, 10 = demand and 11 treated as block. In block mode a gap starts only on a beat flagged end-of-block, or on a beat flagged end-of-transfer.
- R8: In burst mode beats never start a gap, even when flagged end-of-block. Only a beat flagged end-of-transfer does.
- R9: In demand mode every beat starts a gap. A gap also starts when the granted channel drops its request.
- R10: A gap holds the bus request low for exactly GAP_CYC cycles (default 4) when a request is waiting. The arbitration result appears in the next cycle.
- R11: Clearing the run enable during a transfer leaves the current grant active until its next gap. After that gap the bus stays released.
- R12: The stop status becomes 1 once a disable or halt, requested while a channel was active, has brought every channel to rest. It returns to 0 one cycle after the condition is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 32 | Control word write data |
| cfg_rdata_o | output | 32 | Control word read value |
| ch_req_i | input | NCH | Per-channel transfer request |
| ch_mode_i | input | 2*NCH | Per-channel transfer mode, 2 bits each |
| beat_i | input | 1 | Granted channel completed one beat |
| blk_last_i | input | 1 | Qualifies beat_i: block counter reached zero |
| xfer_last_i | input | 1 | Qualifies beat_i: whole transfer done |
| bus_req_o | output | 1 | Bus request to the system arbiter |
| grant_o | output | NCH | One-hot granted channel |

## Verification
The bench targets the gap rules in each mode. A design that treats every beat as a gap would fail the block and burst holds. One that ignores the renegotiation case in demand mode would keep the bus after the request drops. The rotation pointer is tested across the wrap from channel 7 to channel 2, where a pointer that fails to wrap modulo the channel count would pick the wrong winner. The gap length is measured exactly, so an off-by-one counter shows up. Disable and halt are applied mid-transfer and must wait for the gap. The stop flag must rise only after the engine is idle and must fall one cycle after release, which catches a flag tied to the register bit instead of to the activity.

// File: rtl/dmac_gctl_pkg.sv
package dmac_gctl_pkg;
  typedef enum logic [1:0] {
    XM_BLOCK  = 2'b00,
    XM_BURST  = 2'b01,
    XM_DEMAND = 2'b10,
    XM_RSVD   = 2'b11
  } xfer_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_GAP
  } arb_state_e;

  localparam int unsigned CFG_W      = 32;
  localparam int unsigned CFG_RUN    = 31;
  localparam int unsigned CFG_STOP   = 30;
  localparam int unsigned CFG_ROT    = 28;
  localparam int unsigned CFG_HLT_LO = 24;
  localparam int unsigned HLT_W      = 4;
endpackage

// File: rtl/dmac_gcfg_reg.sv
module dmac_gcfg_reg
  import dmac_gctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             active_i,
  output logic [CFG_W-1:0] rdata_o,
  output logic             run_o,
  output logic             rot_o
);
  logic             en_q, rot_q, pend_q, stop_q;
  logic [HLT_W-1:0] hlt_q;
  logic             stop_req;

  assign stop_req = !en_q || (hlt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      rot_q <= 1'b0;
      hlt_q <= '0;
    end else if (we_i) begin
      en_q  <= wdata_i[CFG_RUN];
      rot_q <= wdata_i[CFG_ROT];
      hlt_q <= wdata_i[CFG_HLT_LO +: HLT_W];
    end
  end

  // stop flag only after a stop that caught a live channel
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      stop_q <= 1'b0;
    end else if (!stop_req) begin
      pend_q <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      if (active_i) pend_q <= 1'b1;
      if (pend_q && !active_i) stop_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o                        = '0;
    rdata_o[CFG_RUN]               = en_q;
    rdata_o[CFG_STOP]              = stop_q;
    rdata_o[CFG_ROT]               = rot_q;
    rdata_o[CFG_HLT_LO +: HLT_W]   = hlt_q;
  end

  assign run_o = !stop_req;
  assign rot_o = rot_q;
endmodule

// File: rtl/dmac_prio_pick.sv
module dmac_prio_pick #(
  parameter int unsigned NCH = 8,
  localparam int unsigned IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] req_i,
  input  logic           rot_i,
  input  logic [IW-1:0]  last_i,
  output logic [IW-1:0]  idx_o,
  output logic           vld_o
);
  int unsigned base_n;
  int unsigned cand;

  always_comb begin
    base_n = 0;
    if (rot_i) base_n = (int'(last_i) >= NCH - 1) ? 0 : int'(last_i) + 1;
    vld_o = 1'b0;
    idx_o = '0;
    cand  = 0;
    for (int k = 0; k < NCH; k++) begin
      cand = base_n + k;
      if (cand >= NCH) cand = cand - NCH;
      if (!vld_o && req_i[cand]) begin
        vld_o = 1'b1;
        idx_o = IW'(cand);
      end
    end
  end
endmodule

// File: rtl/dmac_gap_fsm.sv
module dmac_gap_fsm
  import dmac_gctl_pkg::*;
#(
  parameter int unsigned NCH     = 8,
  parameter int unsigned GAP_CYC = 4,
  localparam int unsigned IW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int unsigned CW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           win_vld_i,
  input  logic [IW-1:0]  win_idx_i,
  input  logic           gap_i,
  output logic           active_o,
  output logic [IW-1:0]  gidx_o,
  output logic [IW-1:0]  last_o,
  output logic           bus_req_o,
  output logic [NCH-1:0] grant_o
);
  arb_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] gidx_q, last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      gidx_q  <= '0;
      last_q  <= IW'(NCH - 1);
    end else begin
      unique case (state_q)
        ST_XFER: if (gap_i) begin
          state_q <= ST_GAP;
          cnt_q   <= CW'(GAP_CYC - 1);
        end
        default: begin
          if (state_q == ST_GAP && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (run_i && win_vld_i) begin
            state_q <= ST_XFER;
            gidx_q  <= win_idx_i;
            last_q  <= win_idx_i;
          end else begin
            state_q <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign active_o  = (state_q != ST_IDLE);
  assign bus_req_o = (state_q == ST_XFER);
  assign grant_o   = bus_req_o ? (NCH'(1) << gidx_q) : '0;
  assign gidx_o    = gidx_q;
  assign last_o    = last_q;
endmodule

// File: rtl/dmac_gctl_core.sv
module dmac_gctl_core
  import dmac_gctl_pkg::*;
#(
  parameter int unsigned NCH     = 8,
  parameter int unsigned GAP_CYC = 4,
  localparam int unsigned IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [31:0]      cfg_wdata_i,
  output logic [31:0]      cfg_rdata_o,
  input  logic [NCH-1:0]   ch_req_i,
  input  logic [2*NCH-1:0] ch_mode_i,
  input  logic             beat_i,
  input  logic             blk_last_i,
  input  logic             xfer_last_i,
  output logic             bus_req_o,
  output logic [NCH-1:0]   grant_o
);
  logic           run, rot, active, win_vld, gap;
  logic [IW-1:0]  win_idx, gidx, last_idx;
  logic [NCH-1:0] gap_ch;

  dmac_gcfg_reg u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .wdata_i  (cfg_wdata_i),
    .active_i (active),
    .rdata_o  (cfg_rdata_o),
    .run_o    (run),
    .rot_o    (rot)
  );

  dmac_prio_pick #(.NCH(NCH)) u_pick (
    .req_i  (ch_req_i),
    .rot_i  (rot),
    .last_i (last_idx),
    .idx_o  (win_idx),
    .vld_o  (win_vld)
  );

  // per-channel gap point by transfer mode
  for (genvar c = 0; c < NCH; c++) begin : g_gap
    xfer_mode_e mode;
    assign mode = xfer_mode_e'(ch_mode_i[2*c +: 2]);
    always_comb begin
      unique case (mode)
        XM_DEMAND: gap_ch[c] = beat_i || !ch_req_i[c];
        XM_BURST:  gap_ch[c] = 1'b0;
        default:   gap_ch[c] = beat_i && blk_last_i;
      endcase
    end
  end

  assign gap = gap_ch[gidx] || (beat_i && xfer_last_i);

  dmac_gap_fsm #(.NCH(NCH), .GAP_CYC(GAP_CYC)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .win_vld_i (win_vld),
    .win_idx_i (win_idx),
    .gap_i     (gap),
    .active_o  (active),
    .gidx_o    (gidx),
    .last_o    (last_idx),
    .bus_req_o (bus_req_o),
    .grant_o   (grant_o)
  );
endmodule

// File: rtl/dmac_gctl_chk.sv
module dmac_gctl_chk #(
  parameter int unsigned NCH     = 8,
  parameter int unsigned GAP_CYC = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [31:0]      cfg_rdata_o,
  input logic [NCH-1:0]   ch_req_i,
  input logic [2*NCH-1:0] ch_mode_i,
  input logic             beat_i,
  input logic             blk_last_i,
  input logic             xfer_last_i,
  input logic             bus_req_o,
  input logic [NCH-1:0]   grant_o
);
  logic [1:0] gmode;
  logic       gdrop;
  int unsigned lo_cnt_q;
  logic        was_hi_q;

  always_comb begin
    gmode = 2'b00;
    gdrop = 1'b0;
    for (int c = 0; c < NCH; c++)
      if (grant_o[c]) begin
        gmode = ch_mode_i[2*c +: 2];
        gdrop = !ch_req_i[c];
      end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt_q <= 0;
      was_hi_q <= 1'b0;
    end else begin
      if (bus_req_o) begin
        lo_cnt_q <= 0;
        was_hi_q <= 1'b1;
      end else if (lo_cnt_q < GAP_CYC) begin
        lo_cnt_q <= lo_cnt_q + 1;
      end
    end
  end

  // R2
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[29] == 1'b0 && cfg_rdata_o[23:0] == '0);

  // R3
  stopped_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_req_o && (!cfg_rdata_o[31] || cfg_rdata_o[27:24] != '0)) |=> !bus_req_o);

  // R6
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  // R6
  grant_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && $past(bus_req_o)) |-> $stable(grant_o));

  // R7
  block_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && (gmode == 2'b00 || gmode == 2'b11) && !(beat_i && (blk_last_i || xfer_last_i)))
      |=> bus_req_o);

  // R8
  burst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && gmode == 2'b01 && !(beat_i && xfer_last_i)) |=> bus_req_o);

  // R9
  demand_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && gmode == 2'b10 && (beat_i || gdrop)) |=> !bus_req_o);

  // R10
  gap_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_req_o && was_hi_q && (lo_cnt_q + 1 < GAP_CYC)) |=> !bus_req_o);

  // R12
  stop_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[30] |-> !bus_req_o);
endmodule

bind dmac_gctl_core dmac_gctl_chk #(.NCH(NCH), .GAP_CYC(GAP_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_rdata_o (cfg_rdata_o),
  .ch_req_i    (ch_req_i),
  .ch_mode_i   (ch_mode_i),
  .beat_i      (beat_i),
  .blk_last_i  (blk_last_i),
  .xfer_last_i (xfer_last_i),
  .bus_req_o   (bus_req_o),
  .grant_o     (grant_o)
);

// File: tb/dmac_gctl_core_tb_top.sv
`timescale 1ns/1ps
module dmac_gctl_core_tb_top;
  localparam int NCH = 8;
  localparam int GAP = 4;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cfg_we_i = 1'b0;
  logic [31:0]      cfg_wdata_i = '0;
  logic [31:0]      cfg_rdata_o;
  logic [NCH-1:0]   ch_req_i = '0;
  logic [2*NCH-1:0] ch_mode_i = '0;
  logic             beat_i = 1'b0, blk_last_i = 1'b0, xfer_last_i = 1'b0;
  logic             bus_req_o;
  logic [NCH-1:0]   grant_o;

  int n_chk = 0, n_err = 0;
  int exp_q[$];
  logic prev_req = 1'b0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  dmac_gctl_core #(.NCH(NCH), .GAP_CYC(GAP)) dut_i (.*);

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  // scoreboard monitor: each new bus ownership pops one expected channel
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (bus_req_o && !prev_req) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4/R5 unexpected grant", 32'(grant_o), 32'h0);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(grant_o == NCH'(1) << e, "R4/R5 grant order", 32'(grant_o), 32'(1) << e);
        end
      end
      prev_req = bus_req_o;
    end
  end

  task automatic wr_cfg(input logic [31:0] d);
    cfg_we_i = 1'b1; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic beat(input logic bl, input logic xl);
    beat_i = 1'b1; blk_last_i = bl; xfer_last_i = xl;
    @(negedge clk_i);
    beat_i = 1'b0; blk_last_i = 1'b0; xfer_last_i = 1'b0;
  endtask

  // R10: count low cycles up to the next grant
  task automatic wait_rise(input int exact, input string rq);
    int cnt = 0;
    while (!bus_req_o && cnt < 50) begin
      cnt++;
      @(negedge clk_i);
    end
    if (exact >= 0) chk(cnt == exact, rq, 32'(cnt), 32'(exact));
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(cfg_rdata_o == 32'h0 && !bus_req_o && grant_o == '0, "R1 reset",
        cfg_rdata_o | 32'(bus_req_o) | 32'(grant_o), 32'h0);

    wr_cfg(32'hFFFF_FFFF);
    chk(cfg_rdata_o == 32'h9F00_0000, "R2 write ones", cfg_rdata_o, 32'h9F00_0000);
    wr_cfg(32'h0);
    chk(cfg_rdata_o == 32'h0, "R2 clear", cfg_rdata_o, 32'h0);

    ch_req_i = 8'hA4;
    repeat (3) @(negedge clk_i);
    chk(!bus_req_o, "R3 disabled no grant", 32'(bus_req_o), 32'h0);

    exp_q.push_back(2);
    wr_cfg(32'h8000_0000);
    wait_rise(-1, "R4");
    repeat (3) beat(1'b0, 1'b0);
    chk(bus_req_o && grant_o == 8'h04, "R7 block hold", 32'(grant_o), 32'h4);

    exp_q.push_back(2);
    beat(1'b1, 1'b0);
    wait_rise(GAP, "R10 block gap length");

    exp_q.push_back(5);
    ch_req_i = 8'hA0;
    beat(1'b0, 1'b1);
    wait_rise(GAP, "R10 end-of-transfer gap");

    wr_cfg(32'h9000_0000);
    ch_req_i = 8'hA4;
    exp_q.push_back(7);
    beat(1'b1, 1'b0);
    wait_rise(GAP, "R5 gap");
    exp_q.push_back(2);
    beat(1'b1, 1'b0);
    wait_rise(GAP, "R5 wrap gap");

    ch_mode_i[5:4] = 2'b01;
    repeat (3) beat(1'b1, 1'b0);
    chk(bus_req_o && grant_o == 8'h04, "R8 burst hold", 32'(grant_o), 32'h4);
    exp_q.push_back(5);
    ch_req_i = 8'hA0;
    beat(1'b0, 1'b1);
    wait_rise(GAP, "R8 burst end gap");

    ch_mode_i[11:10] = 2'b10;
    ch_mode_i[15:14] = 2'b10;
    @(negedge clk_i);
    chk(bus_req_o, "R9 demand no beat holds", 32'(bus_req_o), 32'h1);
    exp_q.push_back(7);
    beat(1'b0, 1'b0);
    chk(!bus_req_o, "R9 demand beat gap", 32'(bus_req_o), 32'h0);
    wait_rise(GAP, "R9 demand gap length");
    exp_q.push_back(5);
    ch_req_i = 8'h20;
    @(negedge clk_i);
    chk(!bus_req_o, "R9 renegotiation gap", 32'(bus_req_o), 32'h0);
    wait_rise(GAP, "R9 renegotiation length");

    wr_cfg(32'h1000_0000);
    chk(bus_req_o && grant_o == 8'h20, "R11 holds until gap", 32'(grant_o), 32'h20);
    chk(!cfg_rdata_o[30], "R12 not yet stopped", cfg_rdata_o, 32'h1000_0000);
    beat(1'b0, 1'b0);
    repeat (8) @(negedge clk_i);
    chk(!bus_req_o, "R11 released after gap", 32'(bus_req_o), 32'h0);
    chk(cfg_rdata_o == 32'h5000_0000, "R12 stop set", cfg_rdata_o, 32'h5000_0000);

    exp_q.push_back(5);
    wr_cfg(32'h9000_0000);
    @(negedge clk_i);
    chk(cfg_rdata_o == 32'h9000_0000, "R12 stop cleared", cfg_rdata_o, 32'h9000_0000);

    wr_cfg(32'h9300_0000);
    chk(bus_req_o, "R3 halt waits for gap", 32'(bus_req_o), 32'h1);
    beat(1'b0, 1'b0);
    repeat (8) @(negedge clk_i);
    chk(!bus_req_o, "R3 halted no grant", 32'(bus_req_o), 32'h0);
    chk(cfg_rdata_o == 32'hD300_0000, "R12 halt stop", cfg_rdata_o, 32'hD300_0000);
    exp_q.push_back(5);
    wr_cfg(32'h9000_0000);
    @(negedge clk_i);
    chk(!cfg_rdata_o[30] && bus_req_o, "R12 halt release", cfg_rdata_o, 32'h9000_0000);

    repeat (4) @(negedge clk_i);
    chk(exp_q.size() == 0, "R4 scoreboard drained", 32'(exp_q.size()), 32'h0);
    finish_run();
  end
endmodule